// File: doc/BRIEF.md
# Demand-Mode DMA Channel Sequencer

This block is the control sequencer of one DMA channel working in demand mode. A peripheral raises a request line and the channel runs a buffer transfer on a simple bus-master port. It asks for the bus, waits for a grant, and then issues transfers back to back. Each transfer is an address-strobe state followed by one or more wait states that end when ready is seen. The transfers continue for as long as the peripheral keeps its request up. When the request falls, the channel finishes the bus cycle it is in, hands the bus back and parks in a suspended state. That state keeps the remaining count and the current address, so a later request continues the buffer where it stopped.

Software loads a base address and a transfer count through a one-cycle load strobe. A buffer ends in one of two ways: the count reaches its terminal value, or the peripheral pulls the active-low terminate input. After either end, the channel goes idle in single mode, or reloads the base values and stays armed in autoinitialize mode. A configuration input selects when the request is checked during a buffer. In one mode it is checked only in the final state of each transfer. In the other it is checked in every bus state. The request that starts a buffer is always taken as soon as it is seen.

Top module: `dma_demand_chan`

## Requirements
- R1: After reset, bus_req_o, bus_strobe_o, xfer_done_o and eop_o are 0 and cnt_o is 0.
- R2: With the channel armed and idle, a request driven high on dreq_i raises bus_req_o in the third clock edge after it (two synchronizer stages and one state register). After the grant, a transfer has one strobe cycle (bus_strobe_o high, never two cycles in a row) followed by wait states. The transfer completes in the first wait state with bus_ready_i high, which is marked by xfer_done_o.
- R3: While the synchronized request stays high, the next strobe follows the completing wait state directly, and bus_req_o stays high across the whole buffer.
- R4: When the request is low at the decision point, the channel completes the current transfer, drops bus_req_o and holds cnt_o and bus_addr_o unchanged until a request returns. It then resumes the same buffer with a new bus request.
- R5: Each completed transfer lowers cnt_o by one. It also moves the address by one: up when cfg_dir_dn_i is 0, down when it is 1.
- R6: The transfer that completes with cnt_o equal to 1 ends the buffer, and eop_o is high for that one cycle only, together with xfer_done_o.
- R7: eop_ni low in any state of a transfer in progress ends the buffer once that transfer completes, whatever the count. That transfer is counted, and eop_o does not pulse.
- R8: In single mode (cfg_auto_i = 0), a finished buffer disarms the channel. Further requests start no transfer, and cnt_o keeps its final value.
- R9: In autoinitialize mode (cfg_auto_i = 1), a finished buffer reloads cnt_o and the address from the loaded base values, and the channel stays armed.
- R10: With cfg_async_i = 0, only the request value in the final wait state decides whether the buffer continues. A dip elsewhere in the transfer has no effect.
- R11: With cfg_async_i = 1, a low request in any state of a transfer makes the channel release the bus after that transfer.
- R12: Loading a count of 0 leaves the channel disarmed, so a request raises no bus_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | One-cycle strobe that loads base and current address/count |
| cfg_addr_i | input | AW | Base address to load |
| cfg_cnt_i | input | CW | Transfer count to load |
| cfg_auto_i | input | 1 | 1: autoinitialize, 0: single |
| cfg_async_i | input | 1 | 1: check request every bus state, 0: only in final state |
| cfg_dir_dn_i | input | 1 | 1: address counts down, 0: up |
| dreq_i | input | 1 | Peripheral request, asynchronous |
| eop_ni | input | 1 | Terminate buffer, active low |
| bus_req_o | output | 1 | Bus request / ownership |
| bus_gnt_i | input | 1 | Bus grant |
| bus_strobe_o | output | 1 | Address strobe, first state of a transfer |
| bus_addr_o | output | AW | Current transfer address |
| bus_ready_i | input | 1 | Ends a wait state |
| xfer_done_o | output | 1 | One-cycle mark of a completed transfer |
| eop_o | output | 1 | One-cycle pulse on terminal count |
| cnt_o | output | CW | Remaining transfer count |

## Verification
The scoreboard predicts every transfer's address and terminal flag. It compares these predictions against the bus in four request patterns, each of which tells a different case apart:
- A steady request must produce an unbroken buffer with one bus release at the end.
- A request dropped right at a terminal count must give exactly one extra transfer of the reloaded buffer, followed by a suspension that keeps count and address.
- A one-cycle dip in the middle of a wait stretch must be ignored by final-state sampling but cause an extra bus release under per-state sampling.
- A terminate pulse in the strobe state, alone or combined with a request drop, must separate early termination from terminal count and single from autoinitialize.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_T1,
    ST_T2,
    ST_SUSP
  } chan_st_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q[g] <= 1'b0;
        else         sr_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q[g] <= 1'b0;
        else         sr_q[g] <= sr_q[g-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] base_cnt_i,
  input  logic          step_i,
  input  logic          dir_dn_i,
  input  logic          reload_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [CW-1:0] cur_cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] ADR_ONE = AW'(1);

  logic [AW-1:0] base_addr_q, addr_q;
  logic [CW-1:0] base_cnt_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
    end else if (load_i) begin
      base_addr_q <= base_addr_i;
      base_cnt_q  <= base_cnt_i;
    end
  end

  // load beats reload beats step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_addr_i;
      cnt_q  <= base_cnt_i;
    end else if (reload_i) begin
      addr_q <= base_addr_q;
      cnt_q  <= base_cnt_q;
    end else if (step_i) begin
      addr_q <= dir_dn_i ? addr_q - ADR_ONE : addr_q + ADR_ONE;
      cnt_q  <= cnt_q - CNT_ONE;
    end
  end

  assign cur_addr_o = addr_q;
  assign cur_cnt_o  = cnt_q;
  assign last_o     = (cnt_q == CNT_ONE);
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic load_nz_i,
  input  logic req_s_i,
  input  logic async_i,
  input  logic auto_i,
  input  logic gnt_i,
  input  logic ready_i,
  input  logic eop_ni,
  input  logic last_i,
  output logic bus_req_o,
  output logic strobe_o,
  output logic xfer_o,
  output logic tc_o,
  output logic reload_o
);
  chan_st_e st_q, st_d;
  logic armed_q, drop_q, eop_q;
  logic in_cyc, fin, keep;

  assign in_cyc = (st_q == ST_T1) || (st_q == ST_T2);
  assign xfer_o = (st_q == ST_T2) && ready_i;
  assign fin    = last_i || eop_q || !eop_ni;
  // per-state mode: any low sample during the transfer stops the burst
  assign keep   = async_i ? (req_s_i && !drop_q) : req_s_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (!load_i && armed_q && req_s_i) st_d = ST_REQ;
      ST_SUSP: begin
        if (load_i)       st_d = ST_IDLE;
        else if (req_s_i) st_d = ST_REQ;
      end
      ST_REQ:  if (gnt_i) st_d = ST_T1;
      ST_T1:   st_d = ST_T2;
      ST_T2:   if (ready_i) st_d = fin ? ST_IDLE : (keep ? ST_T1 : ST_SUSP);
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      armed_q <= 1'b0;
      drop_q  <= 1'b0;
      eop_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load_i)                      armed_q <= load_nz_i;
      else if (xfer_o && fin && !auto_i) armed_q <= 1'b0;
      if (xfer_o)                              drop_q <= 1'b0;
      else if (in_cyc && async_i && !req_s_i)  drop_q <= 1'b1;
      if (xfer_o)                  eop_q <= 1'b0;
      else if (in_cyc && !eop_ni)  eop_q <= 1'b1;
    end
  end

  assign bus_req_o = (st_q == ST_REQ) || in_cyc;
  assign strobe_o  = (st_q == ST_T1);
  assign tc_o      = xfer_o && last_i;
  assign reload_o  = xfer_o && fin && auto_i;
endmodule

// File: rtl/dma_demand_chan.sv
module dma_demand_chan #(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_load_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [CW-1:0] cfg_cnt_i,
  input  logic          cfg_auto_i,
  input  logic          cfg_async_i,
  input  logic          cfg_dir_dn_i,
  input  logic          dreq_i,
  input  logic          eop_ni,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_strobe_o,
  output logic [AW-1:0] bus_addr_o,
  input  logic          bus_ready_i,
  output logic          xfer_done_o,
  output logic          eop_o,
  output logic [CW-1:0] cnt_o
);
  logic req_s, last, xfer, reload;

  dma_req_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dreq_i),
    .q_o   (req_s)
  );

  dma_chan_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cfg_load_i),
    .load_nz_i(cfg_cnt_i != '0),
    .req_s_i  (req_s),
    .async_i  (cfg_async_i),
    .auto_i   (cfg_auto_i),
    .gnt_i    (bus_gnt_i),
    .ready_i  (bus_ready_i),
    .eop_ni   (eop_ni),
    .last_i   (last),
    .bus_req_o(bus_req_o),
    .strobe_o (bus_strobe_o),
    .xfer_o   (xfer),
    .tc_o     (eop_o),
    .reload_o (reload)
  );

  dma_xfer_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_load_i),
    .base_addr_i(cfg_addr_i),
    .base_cnt_i (cfg_cnt_i),
    .step_i     (xfer),
    .dir_dn_i   (cfg_dir_dn_i),
    .reload_i   (reload),
    .cur_addr_o (bus_addr_o),
    .cur_cnt_o  (cnt_o),
    .last_o     (last)
  );

  assign xfer_done_o = xfer;
endmodule

// File: rtl/dma_demand_chan_chk.sv
module dma_demand_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_load_i,
  input logic          cfg_auto_i,
  input logic          bus_req_o,
  input logic          bus_strobe_o,
  input logic          xfer_done_o,
  input logic          eop_o,
  input logic [CW-1:0] cnt_o
);
  // R2
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_strobe_o |=> !bus_strobe_o);
  // R2
  strobe_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_strobe_o, xfer_done_o}));
  // R3
  strobe_owns_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_strobe_o || xfer_done_o) |-> bus_req_o);
  // R4
  idle_cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && !cfg_load_i) |=> cnt_o == $past(cnt_o));
  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_o && !cfg_auto_i && !cfg_load_i) |=> cnt_o == $past(cnt_o) - CW'(1));
  // R6
  eop_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> (xfer_done_o && cnt_o == CW'(1)));
  // R6
  eop_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !eop_o);
endmodule

bind dma_demand_chan dma_demand_chan_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_load_i  (cfg_load_i),
  .cfg_auto_i  (cfg_auto_i),
  .bus_req_o   (bus_req_o),
  .bus_strobe_o(bus_strobe_o),
  .xfer_done_o (xfer_done_o),
  .eop_o       (eop_o),
  .cnt_o       (cnt_o)
);

// File: tb/tb_dma_demand_chan.sv
`timescale 1ns/1ps
module tb_dma_demand_chan;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, cfg_auto = 0, cfg_async = 0, cfg_dn = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic dreq = 0, eop_n = 1, gnt, ready;
  logic bus_req, strobe, xfer, eop;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt;
  logic [3:0] wcnt;
  int ws = 0;
  int n_cmp = 0, n_bad = 0, falls = 0;
  logic prev_req = 0;
  logic [AW:0] exp_q[$];

  always #5 clk = ~clk;

  dma_demand_chan #(.AW(AW), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_addr_i(cfg_addr),
    .cfg_cnt_i(cfg_cnt), .cfg_auto_i(cfg_auto), .cfg_async_i(cfg_async),
    .cfg_dir_dn_i(cfg_dn), .dreq_i(dreq), .eop_ni(eop_n), .bus_req_o(bus_req),
    .bus_gnt_i(gnt), .bus_strobe_o(strobe), .bus_addr_o(addr), .bus_ready_i(ready),
    .xfer_done_o(xfer), .eop_o(eop), .cnt_o(cnt)
  );

  // bus slave: grant follows request by one cycle, ws wait states after strobe
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt  <= 1'b0;
      wcnt <= '0;
    end else begin
      gnt <= bus_req;
      if (strobe)          wcnt <= 4'(ws);
      else if (wcnt != 0)  wcnt <= wcnt - 4'd1;
    end
  end
  assign ready = (wcnt == 0);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each completed transfer against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_req && !bus_req) falls++;
      prev_req = bus_req;
      if (xfer) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected transfer", int'({eop, addr}), 0);
        end else begin
          logic [AW:0] e;
          e = exp_q.pop_front();
          chk({eop, addr} == e, "R5/R6 transfer addr/eop", int'({eop, addr}), int'(e));
        end
      end
    end
  end

  task automatic push_buf(input logic [AW-1:0] base, input int n, input bit dn, input bit tc_last);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      a = dn ? base - AW'(i) : base + AW'(i);
      exp_q.push_back({tc_last && (i == n - 1), a});
    end
  endtask

  task automatic load_cfg(input logic [AW-1:0] a, input logic [CW-1:0] n,
                          input logic au, input logic as, input logic dn);
    @(negedge clk);
    cfg_addr = a; cfg_cnt = n; cfg_auto = au; cfg_async = as; cfg_dn = dn; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !bus_req) break;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_strobe();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (strobe) break;
    end
  endtask

  task automatic wait_eop();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (eop) break;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!bus_req && !strobe && !xfer && !eop, "R1 outputs idle", int'({bus_req, strobe, xfer, eop}), 0);
    chk(cnt == 0, "R1 count", int'(cnt), 0);

    // R2 R3 R6 R8: steady request, single, up, sync
    load_cfg(16'h0100, 16'd4, 0, 0, 0);
    push_buf(16'h0100, 4, 0, 1);
    falls = 0;
    dreq = 1;
    repeat (2) @(negedge clk);
    chk(!bus_req, "R2 no request before sync", int'(bus_req), 0);
    @(negedge clk);
    chk(bus_req, "R2 request after sync", int'(bus_req), 1);
    wait_idle();
    chk(exp_q.size() == 0, "R3 all transfers seen", exp_q.size(), 0);
    chk(falls == 1, "R3 single bus release", falls, 1);
    chk(cnt == 0, "R8 final count", int'(cnt), 0);
    chk(addr == 16'h0104, "R5 final address", int'(addr), 16'h0104);
    repeat (20) @(negedge clk);
    chk(!bus_req, "R8 request ignored after buffer", int'(bus_req), 0);
    dreq = 0;
    repeat (4) @(negedge clk);

    // R4 R9: autoinit, down; drop request at terminal count
    load_cfg(16'h0200, 16'd3, 1, 0, 1);
    push_buf(16'h0200, 3, 1, 1);
    push_buf(16'h0200, 1, 1, 0);
    dreq = 1;
    wait_eop();
    dreq = 0;
    wait_idle();
    chk(exp_q.size() == 0, "R9 reload then one transfer", exp_q.size(), 0);
    chk(cnt == 2, "R4 count held in suspend", int'(cnt), 2);
    chk(addr == 16'h01FF, "R4 address held in suspend", int'(addr), 16'h01FF);
    chk(!bus_req, "R4 bus released", int'(bus_req), 0);
    exp_q.push_back({1'b0, 16'h01FF});
    exp_q.push_back({1'b1, 16'h01FE});
    exp_q.push_back({1'b0, 16'h0200});
    dreq = 1;
    wait_eop();
    dreq = 0;
    wait_idle();
    chk(exp_q.size() == 0, "R4 resume completes buffer", exp_q.size(), 0);
    chk(cnt == 2, "R9 reloaded count", int'(cnt), 2);

    // R10: mid-transfer dip, final-state sampling
    ws = 3;
    load_cfg(16'h0400, 16'd3, 0, 0, 0);
    push_buf(16'h0400, 3, 0, 1);
    falls = 0;
    dreq = 1;
    wait_strobe();
    dreq = 0;
    @(negedge clk);
    dreq = 1;
    wait_idle();
    chk(exp_q.size() == 0, "R10 transfers", exp_q.size(), 0);
    chk(falls == 1, "R10 dip ignored", falls, 1);
    dreq = 0;
    repeat (4) @(negedge clk);

    // R11: same dip, per-state sampling
    load_cfg(16'h0500, 16'd3, 0, 1, 0);
    push_buf(16'h0500, 3, 0, 1);
    falls = 0;
    dreq = 1;
    wait_strobe();
    dreq = 0;
    @(negedge clk);
    dreq = 1;
    wait_idle();
    chk(exp_q.size() == 0, "R11 transfers", exp_q.size(), 0);
    chk(falls == 2, "R11 dip releases bus", falls, 2);
    dreq = 0;
    repeat (4) @(negedge clk);

    // R7: terminate in strobe state, single
    load_cfg(16'h0300, 16'd5, 0, 0, 0);
    push_buf(16'h0300, 1, 0, 0);
    dreq = 1;
    wait_strobe();
    eop_n = 0;
    @(negedge clk);
    eop_n = 1;
    wait_idle();
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7 one transfer", exp_q.size(), 0);
    chk(cnt == 4, "R7 count after terminate", int'(cnt), 4);
    chk(addr == 16'h0301, "R7 address after terminate", int'(addr), 16'h0301);
    chk(!bus_req, "R7 idle after terminate", int'(bus_req), 0);
    dreq = 0;
    repeat (4) @(negedge clk);

    // R7 R9: terminate with request drop, autoinit reloads
    load_cfg(16'h0600, 16'd5, 1, 0, 0);
    push_buf(16'h0600, 1, 0, 0);
    dreq = 1;
    wait_strobe();
    eop_n = 0;
    dreq = 0;
    @(negedge clk);
    eop_n = 1;
    wait_idle();
    chk(exp_q.size() == 0, "R7 auto one transfer", exp_q.size(), 0);
    chk(cnt == 5, "R9 count reloaded", int'(cnt), 5);
    chk(addr == 16'h0600, "R9 address reloaded", int'(addr), 16'h0600);

    // R12: zero count leaves channel disarmed
    ws = 0;
    load_cfg(16'h0700, 16'd0, 0, 0, 0);
    dreq = 1;
    repeat (20) @(negedge clk);
    chk(!bus_req, "R12 no request with zero count", int'(bus_req), 0);
    chk(cnt == 0, "R12 count", int'(cnt), 0);
    dreq = 0;
    repeat (4) @(negedge clk);

    summary();
  end
endmodule